// File: doc/BRIEF.md
# Floating-Point Control and Status Word

This block keeps the 32-bit control and status word of a floating-point unit. After each arithmetic operation the datapath reports which IEEE exceptions the operation raised (inexact, underflow, overflow, divide by zero, invalid) and whether the operation was unimplemented. The block replaces the cause field of the word with that report and ORs the same bits into the sticky flags. It then decides in the same cycle whether the operation must trap. A trap happens when a cause bit meets its enable bit, or when the unimplemented cause is set. On a trap the result-register write strobe is held low, so the register file is never updated by a trapping operation.

Software reaches the word through control-register moves. A write to index 31 replaces the whole word and runs the same trap test on the new value. Writes to any other index have no effect. A read of index 31 returns the word, and a read of any other index, including the revision index 0, returns zero. The block also exposes the rounding mode and the denormal-flush control, and it holds eight condition bits. A compare operation writes one of them, and a selector reads one of them back for conditional branches and moves.

Top module: `fcsr_unit`

## Requirements
- R1: After reset the status word is all zeros, so the rounding mode is round-to-nearest.
- R2: `round_mode` equals word bits 1:0 (0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf), and `flush_den` equals word bit 24.
- R3: An accepted operation overwrites the cause field, bits 16:12, with `op_exc` (bit 0 inexact, 1 underflow, 2 overflow, 3 divide by zero, 4 invalid). It also writes bit 17 with `op_unimpl`.
- R4: An accepted operation ORs `op_exc` into the sticky flags, bits 6:2, in the same bit order. No operation ever clears a flag.
- R5: `trap` is high during an accepted operation when the updated word has a cause bit whose enable bit (bits 11:7, the cause field shifted right by 5) is set, or when it has bit 17 set. `result_we` is `op_valid` and not `trap`.
- R6: A compare operation that does not trap writes `cmp_true` into the condition bit chosen by `cmp_cc`. Code 0 is bit 23 and code k (1 to 7) is bit 24+k. A trapping compare leaves every condition bit unchanged, but its cause and flag updates still take place.
- R7: A control write to index 31 replaces the whole word. During that cycle `trap` shows the R5 test applied to the written value. A control write to any other index changes nothing and leaves `trap` low.
- R8: `ctl_rdata` is the word when `ctl_rd_idx` is 31 and zero for every other index.
- R9: When `ctl_wr` and `op_valid` are high together, the control write takes effect and the operation is dropped: `result_we` is low and the word gets no cause or flag update.
- R10: `cc_out` is the condition bit chosen by `cc_sel`, using the mapping of R6.
- R11: With neither `op_valid` nor `ctl_wr` high, the word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An arithmetic operation completes this cycle |
| op_exc | input | 5 | Exceptions raised by the operation |
| op_unimpl | input | 1 | Operation is unimplemented |
| op_is_cmp | input | 1 | Operation is a compare |
| cmp_cc | input | 3 | Condition code written by a compare |
| cmp_true | input | 1 | Compare outcome |
| result_we | output | 1 | Result register write strobe |
| trap | output | 1 | Trap request |
| ctl_wr | input | 1 | Control register write |
| ctl_idx | input | 5 | Control register write index |
| ctl_wdata | input | 32 | Control register write value |
| ctl_rd_idx | input | 5 | Control register read index |
| ctl_rdata | output | 32 | Control register read value |
| round_mode | output | 2 | Rounding mode |
| flush_den | output | 1 | Denormal flush control |
| cc_sel | input | 3 | Condition code to read |
| cc_out | output | 1 | Selected condition bit |
| csr_word | output | 32 | Current status word |

## Verification
Random operations run against random enable masks, with exception vectors of varying density. This separates the trapping cases from the non-trapping ones and shows that cause bits are replaced while flags only accumulate. Directed cases hit these situations:
- an exception whose enable is clear next to one whose enable is set;
- the unimplemented bit, which always traps;
- a trapping compare, which must leave its condition bit unchanged;
- writes to indices other than 31, which must be ignored;
- a control write that collides with an operation in the same cycle.

Condition codes 0 and 7 are exercised, which checks that the mapping steps over bit 24.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
    localparam int XLEN       = 32;
    localparam int NEXC       = 5;
    localparam int CAUSE_LO   = 12;
    localparam int FLAG_LO    = 2;
    localparam int ALIGN      = 5;
    localparam int EN_LO      = CAUSE_LO - ALIGN;
    localparam int UNIMPL_BIT = CAUSE_LO + NEXC;
    localparam int FLUSH_BIT  = 24;
    localparam int CC0_BIT    = 23;
    localparam int CC_BASE    = 24;
    localparam int NCC        = 8;
    localparam int CCW        = $clog2(NCC);
    localparam int IDXW       = 5;
    localparam int CSR_IDX    = 31;
    localparam int RMW        = 2;

    typedef struct packed {
        logic [XLEN-1:0] word;
    } fcsr_state_t;

    function automatic int cc_pos(input int k);
        return (k == 0) ? CC0_BIT : CC_BASE + k;
    endfunction
endpackage

// File: rtl/fcsr_trap_test.sv
module fcsr_trap_test
    import fcsr_pkg::*;
(
    input  logic [XLEN-1:0] word,
    output logic            hit
);
    localparam logic [XLEN-1:0] EN_MASK = XLEN'(((1 << NEXC) - 1) << EN_LO);

    logic [XLEN-1:0] aligned;

    always_comb begin
        aligned = word >> ALIGN;
        hit     = (|(aligned & word & EN_MASK)) | word[UNIMPL_BIT];
    end
endmodule

// File: rtl/fcsr_cc_map.sv
module fcsr_cc_map
    import fcsr_pkg::*;
(
    input  logic [CCW-1:0]  sel,
    output logic [XLEN-1:0] mask
);
    logic [NCC-1:0] hit;

    for (genvar k = 0; k < NCC; k++) begin : g_cc
        assign hit[k] = (sel == CCW'(k));
    end

    always_comb begin
        mask = '0;
        for (int k = 0; k < NCC; k++) begin
            mask[cc_pos(k)] = hit[k];
        end
    end
endmodule

// File: rtl/fcsr_next.sv
module fcsr_next
    import fcsr_pkg::*;
(
    input  logic [XLEN-1:0] csr_q,
    input  logic            op_valid,
    input  logic [NEXC-1:0] op_exc,
    input  logic            op_unimpl,
    input  logic            op_is_cmp,
    input  logic [XLEN-1:0] cmp_mask,
    input  logic            cmp_true,
    input  logic            ctl_wr,
    input  logic [IDXW-1:0] ctl_idx,
    input  logic [XLEN-1:0] ctl_wdata,
    output fcsr_state_t     state_d,
    output logic            trap_o,
    output logic            result_we_o
);
    logic [XLEN-1:0] op_word_d;
    logic            op_trap;
    logic            wr_trap;
    logic            wr_hit;

    always_comb begin
        op_word_d = csr_q;
        op_word_d[CAUSE_LO +: NEXC] = op_exc;
        op_word_d[UNIMPL_BIT]       = op_unimpl;
        op_word_d[FLAG_LO +: NEXC]  = csr_q[FLAG_LO +: NEXC] | op_exc;
    end

    fcsr_trap_test u_op_trap (.word(op_word_d), .hit(op_trap));
    fcsr_trap_test u_wr_trap (.word(ctl_wdata), .hit(wr_trap));

    assign wr_hit = ctl_wr && (ctl_idx == IDXW'(CSR_IDX));

    always_comb begin
        state_d.word = csr_q;
        trap_o       = 1'b0;
        result_we_o  = 1'b0;
        if (ctl_wr) begin
            if (wr_hit) begin
                state_d.word = ctl_wdata;
                trap_o       = wr_trap;
            end
        end else if (op_valid) begin
            state_d.word = op_word_d;
            trap_o       = op_trap;
            result_we_o  = !op_trap;
            if (op_is_cmp && !op_trap) begin
                state_d.word = cmp_true ? (op_word_d | cmp_mask)
                                        : (op_word_d & ~cmp_mask);
            end
        end
    end
endmodule

// File: rtl/fcsr_unit.sv
module fcsr_unit
    import fcsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [NEXC-1:0]  op_exc,
    input  logic             op_unimpl,
    input  logic             op_is_cmp,
    input  logic [CCW-1:0]   cmp_cc,
    input  logic             cmp_true,
    output logic             result_we,
    output logic             trap,
    input  logic             ctl_wr,
    input  logic [IDXW-1:0]  ctl_idx,
    input  logic [XLEN-1:0]  ctl_wdata,
    input  logic [IDXW-1:0]  ctl_rd_idx,
    output logic [XLEN-1:0]  ctl_rdata,
    output logic [RMW-1:0]   round_mode,
    output logic             flush_den,
    input  logic [CCW-1:0]   cc_sel,
    output logic             cc_out,
    output logic [XLEN-1:0]  csr_word
);
    fcsr_state_t     state_d;
    fcsr_state_t     state_q;
    logic [XLEN-1:0] cmp_mask;
    logic [XLEN-1:0] rd_mask;

    fcsr_cc_map u_cmp_map (.sel(cmp_cc), .mask(cmp_mask));
    fcsr_cc_map u_rd_map  (.sel(cc_sel), .mask(rd_mask));

    fcsr_next u_next (
        .csr_q       (state_q.word),
        .op_valid    (op_valid),
        .op_exc      (op_exc),
        .op_unimpl   (op_unimpl),
        .op_is_cmp   (op_is_cmp),
        .cmp_mask    (cmp_mask),
        .cmp_true    (cmp_true),
        .ctl_wr      (ctl_wr),
        .ctl_idx     (ctl_idx),
        .ctl_wdata   (ctl_wdata),
        .state_d     (state_d),
        .trap_o      (trap),
        .result_we_o (result_we)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign csr_word   = state_q.word;
    assign round_mode = state_q.word[RMW-1:0];
    assign flush_den  = state_q.word[FLUSH_BIT];
    assign cc_out     = |(state_q.word & rd_mask);
    assign ctl_rdata  = (ctl_rd_idx == IDXW'(CSR_IDX)) ? state_q.word : '0;

    AST_CAUSE_REPLACED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !ctl_wr) |=> (csr_word[CAUSE_LO +: NEXC] == $past(op_exc))); // R3
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> ((csr_word[FLAG_LO +: NEXC] & $past(csr_word[FLAG_LO +: NEXC]))
                     == $past(csr_word[FLAG_LO +: NEXC]))); // R4
    AST_TRAP_BLOCKS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> !result_we); // R5
    AST_TRAP_HOLDS_CC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !ctl_wr && trap) |=>
        ((csr_word & 32'hFF80_0000 & ~32'h0100_0000) ==
         ($past(csr_word) & 32'hFF80_0000 & ~32'h0100_0000))); // R6
    AST_WRITE_DROPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |-> !result_we); // R9
    AST_READ_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd_idx != IDXW'(CSR_IDX)) |-> (ctl_rdata == '0)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !ctl_wr) |=> $stable(csr_word)); // R11
endmodule

// File: tb/fcsr_unit_tb.sv
module fcsr_unit_tb_top;
    localparam int P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 0, op_unimpl = 0, op_is_cmp = 0, cmp_true = 0, ctl_wr = 0;
    logic [4:0]  op_exc = 0, ctl_idx = 0, ctl_rd_idx = 0;
    logic [2:0]  cmp_cc = 0, cc_sel = 0;
    logic [31:0] ctl_wdata = 0;
    logic        result_we, trap, flush_den, cc_out;
    logic [1:0]  round_mode;
    logic [31:0] ctl_rdata, csr_word;

    int n_cmp = 0, n_bad = 0;
    logic [31:0] m = 0;

    always #(P/2) clk = ~clk;

    fcsr_unit dut_i (.*);

    function automatic logic trap_of(input logic [31:0] w);
        return (((w >> 5) & w & 32'h0000_0F80) != 0) || w[17];
    endfunction

    function automatic int ccp(input int k);
        return (k == 0) ? 23 : 24 + k;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // inputs already driven; check combinational outputs, clock, check state
    task automatic step();
        logic [31:0] nx;
        logic et, ewe;
        nx = m; et = 0; ewe = 0;
        if (ctl_wr) begin
            if (ctl_idx == 5'd31) begin nx = ctl_wdata; et = trap_of(ctl_wdata); end
        end else if (op_valid) begin
            nx[16:12] = op_exc;
            nx[17]    = op_unimpl;
            nx[6:2]   = m[6:2] | op_exc;
            et  = trap_of(nx);
            ewe = !et;
            if (op_is_cmp && !et) nx[ccp(int'(cmp_cc))] = cmp_true;
        end
        #(P/4);
        chk("R5/R7 trap", 32'(trap), 32'(et));
        chk("R5/R9 result_we", 32'(result_we), 32'(ewe));
        chk("R8 rdata", ctl_rdata, (ctl_rd_idx == 5'd31) ? m : 32'h0);
        chk("R10 cc_out", 32'(cc_out), 32'(m[ccp(int'(cc_sel))]));
        @(posedge clk);
        m = nx;
        @(negedge clk);
        chk("R3/R4/R6/R11 word", csr_word, m);
        chk("R2 round_mode", 32'(round_mode), 32'(m[1:0]));
        chk("R2 flush_den", 32'(flush_den), 32'(m[24]));
    endtask

    task automatic idle();
        op_valid = 0; ctl_wr = 0; op_is_cmp = 0; op_unimpl = 0; op_exc = 0;
    endtask

    task automatic do_op(input logic [4:0] e, input logic u, input logic c,
                         input logic [2:0] cc, input logic t);
        idle(); op_valid = 1; op_exc = e; op_unimpl = u; op_is_cmp = c;
        cmp_cc = cc; cmp_true = t; step();
    endtask

    task automatic do_wr(input logic [4:0] idx, input logic [31:0] d);
        idle(); ctl_wr = 1; ctl_idx = idx; ctl_wdata = d; step();
    endtask

    initial begin
        #(P * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 reset word", csr_word, 32'h0);
        chk("R1 reset round_mode", 32'(round_mode), 32'h0);
        ctl_rd_idx = 5'd31;
        idle(); step();                                 // R11
        // R7/R2: enable overflow only, set rm=3 and flush
        do_wr(5'd31, 32'h0100_0003 | (32'h1 << 9));
        do_op(5'b00001, 0, 0, 0, 0);                    // inexact, not enabled
        do_op(5'b00100, 0, 0, 0, 0);                    // R5 overflow traps
        do_op(5'b00010, 0, 0, 0, 0);                    // R3 cause replaced, R4 flags kept
        do_op(5'b00000, 1, 0, 0, 0);                    // R5 unimpl traps
        do_op(5'b00000, 0, 1, 3'd0, 1);                 // R6 cc0 -> bit 23
        do_op(5'b00000, 0, 1, 3'd7, 1);                 // R6 cc7 -> bit 31
        do_op(5'b00100, 0, 1, 3'd1, 1);                 // R6 trapping compare: cc1 held
        cc_sel = 3'd7; idle(); step();                  // R10
        cc_sel = 3'd1; idle(); step();
        do_wr(5'd5, 32'hFFFF_FFFF);                     // R7 other index ignored
        ctl_rd_idx = 5'd0; idle(); step();              // R8 revision reads zero
        do_wr(5'd31, 32'h0002_0000);                    // R7 unimpl bit on write traps
        idle(); ctl_wr = 1; ctl_idx = 5'd31; ctl_wdata = 32'h0000_0F80;
        op_valid = 1; op_exc = 5'b11111; step();        // R9 write wins
        // random phase
        for (int i = 0; i < 3000; i++) begin
            idle();
            ctl_rd_idx = ($urandom % 4 == 0) ? 5'($urandom) : 5'd31;
            cc_sel = 3'($urandom);
            if ($urandom % 10 == 0) begin
                ctl_wr = 1;
                ctl_idx = ($urandom % 3 == 0) ? 5'($urandom) : 5'd31;
                ctl_wdata = $urandom & ~32'h0003_F000;
                if ($urandom % 8 == 0) ctl_wdata[17] = 1'b1;
                op_valid = ($urandom % 4 == 0);
            end else if ($urandom % 5 != 0) begin
                op_valid = 1;
                op_exc = 5'($urandom & $urandom & $urandom);
                op_unimpl = ($urandom % 40 == 0);
                op_is_cmp = ($urandom % 3 == 0);
                cmp_cc = 3'($urandom);
                cmp_true = 1'($urandom);
            end
            step();
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule